// File: doc/BRIEF.md
# Byte-Staged Audio Sample Register

This block sits between an 8-bit processor bus and a serial audio shifter and holds one 16-bit sample in each direction. The processor builds an outgoing sample a byte at a time: it first stages the low byte, then writes the high byte. The high-byte write hands the complete sample to the shifter. The transmit buffer then counts as full and the transmit-ready interrupt flag drops. If the low byte was not rewritten since the previous high-byte write, the committed sample carries a zero low byte instead of stale data.

Incoming samples arrive from the shifter as whole 16-bit words. They set the receive-full status and the receive-ready interrupt flag. The processor reads the low byte without side effects, and reading the high byte releases the buffer. A third bus location holds the configured sample length as size minus one. A synchronous restore input, asserted when the chip leaves a deep sleep state, returns every register to its reset value.

Top module: `audio_word_stage`

## Requirements
- R1: After reset, the committed transmit sample is 0x0000, the receive buffer reads 0x00 at addresses 0 and 1, all four status and interrupt flags are low, and address 2 reads 0x0F.
- R2: A bus write to address 0 stages a low byte. The next write to address 1 commits {written byte, staged byte} to the transmit sample output one cycle later.
- R3: A write to address 1 with no address-0 write since the previous address-1 write (or since reset or restore) commits the written byte as high byte and 0x00 as low byte.
- R4: A write to address 1 sets the transmit-full flag and clears the transmit interrupt flag on the next cycle. It takes priority over a shifter take in the same cycle.
- R5: A shifter take while transmit-full is set clears transmit-full and sets the transmit interrupt flag on the next cycle. A take while empty changes nothing.
- R6: A shifter receive strobe captures the 16-bit input sample into the receive buffer and sets receive-full and the receive interrupt flag on the next cycle.
- R7: Address 1 reads the receive high byte. A bus read of address 1 clears receive-full and the receive interrupt flag on the next cycle, unless a receive strobe arrives in the same cycle, which wins.
- R8: Address 0 reads the receive low byte. Reading it, or any access other than an address-1 access, leaves all four flags unchanged.
- R9: Address 2 holds the sample length minus one in bits 4:0 and reads 0 in bits 7:5. Writes store bits 4:0, which drive the word-size output. Address 3 reads 0x00 and ignores writes.
- R10: The restore input returns every register and flag to its R1 value on the next cycle, taking priority over any bus or shifter activity in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lpRestore | input | 1 | Synchronous return to reset state |
| busAddr | input | 2 | Register select: 0 low data, 1 high data, 2 word size |
| busWr | input | 1 | Bus write strobe |
| busRd | input | 1 | Bus read strobe |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Read data of the addressed register |
| txTake | input | 1 | Shifter takes the transmit sample |
| txSample | output | 16 | Committed transmit sample |
| txFull | output | 1 | Transmit buffer holds an untaken sample |
| txIrq | output | 1 | Transmit-ready interrupt flag |
| rxLoad | input | 1 | Shifter delivers a receive sample |
| rxSample | input | 16 | Receive sample from the shifter |
| rxFull | output | 1 | Receive buffer holds an unread sample |
| rxIrq | output | 1 | Receive-ready interrupt flag |
| wordSizeM1 | output | 5 | Configured sample length minus one |

## Verification
The transmit path is first driven with an ordered low-then-high pair, then with two back-to-back high writes. Comparing the two shows whether the staged-byte flag really zeroes the low byte, and is not just keeping the last staged value. Shifter takes are issued both while full and while empty, and in the same cycle as a high write. This separates the set and clear priority from a plain toggle. On the receive side, low-byte reads are interleaved with high-byte reads, and one high-byte read coincides with a new receive strobe. Long randomized traffic then mixes all strobes, unused-address accesses and occasional restores against the cycle model.

// File: rtl/aws_pkg.sv
package aws_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd2;

  // strobes from control to datapath; all are gated off by restore
  typedef struct packed {
    logic restore;
    logic wrLow;
    logic wrHigh;
    logic rdHigh;
    logic wrCfg;
    logic txTake;
    logic rxLoad;
  } stb_t;
endpackage

// File: rtl/aws_ctrl.sv
module aws_ctrl
  import aws_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              lpRestore,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              txTake,
  input  logic              rxLoad,
  output stb_t              stb,
  output logic              txFull,
  output logic              txIrq,
  output logic              rxFull,
  output logic              rxIrq
);
  logic live;
  assign live = !lpRestore;

  always_comb begin
    stb.restore = lpRestore;
    stb.wrLow   = live && busWr && (busAddr == ADDR_LOW);
    stb.wrHigh  = live && busWr && (busAddr == ADDR_HIGH);
    stb.rdHigh  = live && busRd && (busAddr == ADDR_HIGH);
    stb.wrCfg   = live && busWr && (busAddr == ADDR_CFG);
    stb.txTake  = live && txTake;
    stb.rxLoad  = live && rxLoad;
  end

  // transmit side flags: high write beats shifter take
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull <= 1'b0;
      txIrq  <= 1'b0;
    end else if (stb.restore) begin
      txFull <= 1'b0;
      txIrq  <= 1'b0;
    end else if (stb.wrHigh) begin
      txFull <= 1'b1;
      txIrq  <= 1'b0;
    end else if (stb.txTake && txFull) begin
      txFull <= 1'b0;
      txIrq  <= 1'b1;
    end
  end

  // receive side flags: new sample beats high read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      rxIrq  <= 1'b0;
    end else if (stb.restore) begin
      rxFull <= 1'b0;
      rxIrq  <= 1'b0;
    end else if (stb.rxLoad) begin
      rxFull <= 1'b1;
      rxIrq  <= 1'b1;
    end else if (stb.rdHigh) begin
      rxFull <= 1'b0;
      rxIrq  <= 1'b0;
    end
  end

  a_r4_high_write_fills: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_HIGH && !lpRestore) |=> (txFull && !txIrq));

  a_r5_take_empties: assert property (@(posedge clk) disable iff (!rstN)
    (txTake && txFull && !lpRestore && !(busWr && busAddr == ADDR_HIGH))
      |=> (!txFull && txIrq));

  a_r6_rx_flags_set: assert property (@(posedge clk) disable iff (!rstN)
    (rxLoad && !lpRestore) |=> (rxFull && rxIrq));

  a_r7_high_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_HIGH && !rxLoad && !lpRestore) |=> (!rxFull && !rxIrq));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!lpRestore && !rxLoad && !txTake && busAddr != ADDR_HIGH)
      |=> $stable({txFull, txIrq, rxFull, rxIrq}));

  a_r10_flags_restore: assert property (@(posedge clk) disable iff (!rstN)
    lpRestore |=> ({txFull, txIrq, rxFull, rxIrq} == 4'b0000));
endmodule

// File: rtl/aws_dpath.sv
module aws_dpath
  import aws_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned WS_W     = 5,
  parameter int unsigned WS_RESET = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  stb_t                stb,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BYTE_W-1:0]   wrData,
  input  logic [2*BYTE_W-1:0] rxSample,
  output logic [BYTE_W-1:0]   rdData,
  output logic [2*BYTE_W-1:0] txSample,
  output logic [WS_W-1:0]     wordSizeM1
);
  localparam int unsigned SAMPLE_W = 2 * BYTE_W;
  localparam logic [WS_W-1:0] WS_INIT = WS_RESET[WS_W-1:0];

  logic [BYTE_W-1:0]   lowStage;
  logic                lowSeen;
  logic [SAMPLE_W-1:0] txBuf;
  logic [SAMPLE_W-1:0] rxBuf;
  logic [WS_W-1:0]     wordSize;
  logic [BYTE_W-1:0]   commitLow;

  assign commitLow = lowSeen ? lowStage : '0;

  // low-byte staging and its seen flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowStage <= '0;
      lowSeen  <= 1'b0;
    end else if (stb.restore) begin
      lowStage <= '0;
      lowSeen  <= 1'b0;
    end else if (stb.wrLow) begin
      lowStage <= wrData;
      lowSeen  <= 1'b1;
    end else if (stb.wrHigh) begin
      lowSeen  <= 1'b0;
    end
  end

  // committed transmit sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txBuf <= '0;
    else if (stb.restore) txBuf <= '0;
    else if (stb.wrHigh)  txBuf <= {wrData, commitLow};
  end

  // receive buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rxBuf <= '0;
    else if (stb.restore) rxBuf <= '0;
    else if (stb.rxLoad)  rxBuf <= rxSample;
  end

  // word size configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wordSize <= WS_INIT;
    else if (stb.restore) wordSize <= WS_INIT;
    else if (stb.wrCfg)   wordSize <= wrData[WS_W-1:0];
  end

  always_comb begin
    rdData = '0;
    unique case (busAddr)
      ADDR_LOW:  rdData = rxBuf[BYTE_W-1:0];
      ADDR_HIGH: rdData = rxBuf[SAMPLE_W-1:BYTE_W];
      ADDR_CFG:  rdData[WS_W-1:0] = wordSize;
      default:   rdData = '0;
    endcase
  end

  assign txSample   = txBuf;
  assign wordSizeM1 = wordSize;

  a_r2_staged_commit: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrHigh && lowSeen) |=> (txSample[BYTE_W-1:0] == $past(lowStage)));

  a_r3_low_zeroed: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrHigh && !lowSeen) |=> (txSample[BYTE_W-1:0] == '0));

  a_r6_rx_capture: assert property (@(posedge clk) disable iff (!rstN)
    stb.rxLoad |=> (rxBuf == $past(rxSample)));

  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrCfg && !stb.restore) |=> $stable(wordSizeM1));

  a_r10_data_restore: assert property (@(posedge clk) disable iff (!rstN)
    stb.restore |=> (txSample == '0 && rxBuf == '0 && wordSizeM1 == WS_INIT && !lowSeen));
endmodule

// File: rtl/audio_word_stage.sv
module audio_word_stage
  import aws_pkg::*;
#(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned WS_W     = 5,
  parameter int unsigned WS_RESET = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lpRestore,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [BYTE_W-1:0]   rdData,
  input  logic                txTake,
  output logic [2*BYTE_W-1:0] txSample,
  output logic                txFull,
  output logic                txIrq,
  input  logic                rxLoad,
  input  logic [2*BYTE_W-1:0] rxSample,
  output logic                rxFull,
  output logic                rxIrq,
  output logic [WS_W-1:0]     wordSizeM1
);
  stb_t stb;

  aws_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .lpRestore (lpRestore),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busRd     (busRd),
    .txTake    (txTake),
    .rxLoad    (rxLoad),
    .stb       (stb),
    .txFull    (txFull),
    .txIrq     (txIrq),
    .rxFull    (rxFull),
    .rxIrq     (rxIrq)
  );

  aws_dpath #(
    .BYTE_W   (BYTE_W),
    .WS_W     (WS_W),
    .WS_RESET (WS_RESET)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .busAddr    (busAddr),
    .wrData     (wrData),
    .rxSample   (rxSample),
    .rdData     (rdData),
    .txSample   (txSample),
    .wordSizeM1 (wordSizeM1)
  );
endmodule

// File: tb/audio_word_stage_bench.sv
module audio_word_stage_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lpRestore = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [7:0]  wrData = 8'h00;
  logic [7:0]  rdData;
  logic        txTake = 1'b0;
  logic [15:0] txSample;
  logic        txFull, txIrq;
  logic        rxLoad = 1'b0;
  logic [15:0] rxSample = 16'h0000;
  logic        rxFull, rxIrq;
  logic [4:0]  wordSizeM1;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  string phase = "R1 reset state";

  always #4 clk = ~clk;

  audio_word_stage u_audio_word_stage (
    .clk(clk), .rstN(rstN), .lpRestore(lpRestore), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .wrData(wrData), .rdData(rdData),
    .txTake(txTake), .txSample(txSample), .txFull(txFull), .txIrq(txIrq),
    .rxLoad(rxLoad), .rxSample(rxSample), .rxFull(rxFull), .rxIrq(rxIrq),
    .wordSizeM1(wordSizeM1)
  );

  // behavioural reference state
  int mLow, mTx, mRx, mWs;
  bit mSeen, mTxFull, mTxIrq, mRxFull, mRxIrq;

  task automatic modelReset();
    mLow = 0; mSeen = 0; mTx = 0; mRx = 0; mWs = 15;
    mTxFull = 0; mTxIrq = 0; mRxFull = 0; mRxIrq = 0;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN || lpRestore) modelReset();
    else begin
      if (busWr && busAddr == 0) begin mLow = wrData; mSeen = 1; end
      if (busWr && busAddr == 1) begin
        mTx = wrData * 256 + (mSeen ? mLow : 0);
        mSeen = 0;
      end
      if (busWr && busAddr == 2) mWs = wrData % 32;
      if (busWr && busAddr == 1) begin mTxFull = 1; mTxIrq = 0; end
      else if (txTake && mTxFull) begin mTxFull = 0; mTxIrq = 1; end
      if (rxLoad) begin mRx = rxSample; mRxFull = 1; mRxIrq = 1; end
      else if (busRd && busAddr == 1) begin mRxFull = 0; mRxIrq = 0; end
    end
  end

  function automatic int expRead(input logic [1:0] a);
    case (a)
      2'd0: return mRx % 256;
      2'd1: return mRx / 256;
      2'd2: return mWs;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) if (rstN && !done) begin
    check("txSample R2 R3", int'(txSample), mTx);
    check("txFull R4 R5", int'(txFull), int'(mTxFull));
    check("txIrq R4 R5", int'(txIrq), int'(mTxIrq));
    check("rxFull R6 R7", int'(rxFull), int'(mRxFull));
    check("rxIrq R6 R7 R8", int'(rxIrq), int'(mRxIrq));
    check("rdData R7 R8 R9", int'(rdData), expRead(busAddr));
    check("wordSize R9", int'(wordSizeM1), mWs);
  end

  task automatic tick();
    @(posedge clk); #1;
    busWr = 0; busRd = 0; txTake = 0; rxLoad = 0; lpRestore = 0;
  endtask
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; wrData = d; busWr = 1; tick();
  endtask
  task automatic rd(input logic [1:0] a);
    busAddr = a; busRd = 1; tick();
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(posedge clk); #1 rstN = 1;
    phase = "R1 reset state";
    busAddr = 2; idle(1); busAddr = 0; idle(1); busAddr = 1; idle(1);
    phase = "R2 staged commit";
    wr(0, 8'h34); wr(1, 8'h12); idle(1);
    phase = "R3 low zeroed on repeated high";
    wr(1, 8'h56); idle(1);
    phase = "R5 take while full";
    txTake = 1; tick(); idle(1);
    phase = "R5 take while empty";
    txTake = 1; tick(); idle(1);
    phase = "R4 high write beats take";
    wr(0, 8'hAA); busAddr = 1; wrData = 8'hBB; busWr = 1; txTake = 1; tick(); idle(1);
    phase = "R6 receive capture";
    rxSample = 16'hC3D4; rxLoad = 1; tick(); idle(1);
    phase = "R8 low read keeps flags";
    rd(0); rd(0); rd(3);
    phase = "R7 high read releases";
    rd(1); idle(1);
    phase = "R7 load beats high read";
    rxSample = 16'h5A6B; rxLoad = 1; busAddr = 1; busRd = 1; tick(); idle(1);
    phase = "R9 word size config";
    wr(2, 8'hE7); rd(2); wr(3, 8'hFF); rd(3);
    phase = "R10 restore";
    wr(0, 8'h11); busAddr = 1; wrData = 8'h22; busWr = 1; lpRestore = 1; tick();
    rd(2); rd(1);
    phase = "R3 after restore";
    wr(1, 8'h77); idle(1);
    phase = "random R2 R3 R4 R5 R6 R7 R8 R9 R10";
    for (int i = 0; i < 4000; i++) begin
      busAddr = 2'($urandom_range(0, 3));
      wrData = 8'($urandom);
      busWr = ($urandom_range(0, 2) == 0);
      busRd = !busWr && ($urandom_range(0, 1) == 0);
      txTake = ($urandom_range(0, 3) == 0);
      rxLoad = ($urandom_range(0, 4) == 0);
      rxSample = 16'($urandom);
      lpRestore = ($urandom_range(0, 99) == 0);
      tick();
    end
    idle(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule